// File: doc/BRIEF.md
# Sound Generator Bus Control Decoder

This block places a programmable sound generator on two adjacent I/O ports of an 8-bit processor bus. It takes the low byte of the I/O address, the active-low I/O request and the active-low read and write strobes. From these it produces the two bus-control lines of the sound generator: the first control line (`bc1`) and the direction line (`bdir`). Together these two lines select one of four operations: idle, read a register, write a register, or latch a register number.

The even port of the pair is the latch port. Any I/O cycle to the latch port drives both control lines high, so the sound generator takes the data bus as a register number. The read and write strobes are not consulted. The odd port is the data port. On the data port the read strobe drives `bc1` and the write strobe drives `bdir`, so the processor can read or load the selected register. The third control input of the sound generator and its two extra chip-select inputs take fixed levels. The decoder is purely combinational and has no clock and no reset.

The port pair is set by the `BASE_PORT` parameter. `BASE_PORT` must be even and must not lie in ports 0 to 7, because those ports are already taken on the host bus. Elaboration rejects a base that breaks either rule. Data-bus buffering, clock division and wait-state generation belong to other blocks. The block carries no data stream, so every pin is a plain level signal with no handshake.

Top module: `snd_bus_decoder`

## Requirements
- R1: With `iorq_n` low and `io_addr == BASE_PORT` (address bit 0 = 0, the latch port), `bc1` = 1 and `bdir` = 1 for all four combinations of `rd_n` and `wr_n`.
- R2: With `iorq_n` low, `io_addr == BASE_PORT + 1`, `rd_n` = 0 and `wr_n` = 1, the outputs are `bc1` = 1 and `bdir` = 0 (read register).
- R3: With `iorq_n` low, `io_addr == BASE_PORT + 1`, `wr_n` = 0 and `rd_n` = 1, the outputs are `bdir` = 1 and `bc1` = 0 (write register).
- R4: With `iorq_n` low, `io_addr == BASE_PORT + 1` and both strobes high, `bc1` = 0 and `bdir` = 0 (idle).
- R5: While `iorq_n` is high, `bc1` and `bdir` are both 0 for every address and strobe value.
- R6: When `io_addr[7:1]` differs from `BASE_PORT[7:1]`, `bc1` and `bdir` are both 0 whatever `iorq_n`, `rd_n` and `wr_n` are.
- R7: After bits 7..1 match, address bit 0 alone picks the port: 0 selects the latch behaviour of R1 and 1 selects the strobe routing of R2 to R4.
- R8: `bc2` is held at 1, `csel_hi` at 1 and `csel_lo_n` at 0 at all times.
- R9: On the data port, `bc1` equals the inverse of `rd_n` and `bdir` equals the inverse of `wr_n`, independently of each other. So if both strobes are low at the same time, both outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_addr | input | 8 | Low byte of the processor I/O address |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bc1 | output | 1 | First bus-control line of the sound generator |
| bdir | output | 1 | Direction bus-control line of the sound generator |
| bc2 | output | 1 | Second bus-control line, held high |
| csel_hi | output | 1 | Extra chip select, active high, held asserted |
| csel_lo_n | output | 1 | Extra chip select, active low, held asserted |

## Verification
The hardest cases are those a real processor never produces: both strobes low together on the data port, and the strobes toggling while the latch port is selected. The bench drives the strobe pins directly, so it reaches these cases without a processor model. Addresses that differ from the base in only one bit position are the other weak spot. A full sweep of all 256 addresses, under each strobe pattern and both request levels, covers every near miss. That sweep also shows that only the two base addresses can assert a control line.

// File: rtl/snd_bus_pkg.sv
package snd_bus_pkg;

  // Bus operation as seen by the sound generator, coded {bdir, bc1}
  typedef enum logic [1:0] {
    SND_IDLE  = 2'b00,
    SND_READ  = 2'b01,
    SND_WRITE = 2'b10,
    SND_LATCH = 2'b11
  } snd_op_t;

  // Levels for the pins that never change
  localparam logic BC2_LEVEL     = 1'b1;
  localparam logic CSEL_HI_LEVEL = 1'b1;
  localparam logic CSEL_LO_LEVEL = 1'b0;

endpackage

// File: rtl/snd_port_match.sv
module snd_port_match #(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_PORT = ADDR_W'(8)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorq_n,
  output logic              hit_latch,
  output logic              hit_data
);

  localparam int unsigned       TAG_W    = ADDR_W - 1;
  localparam logic [TAG_W-1:0]  BASE_TAG = BASE_PORT[ADDR_W-1:1];

  logic pair_hit;

  // Bits above bit 0 must match the base, and an I/O cycle must be in progress
  always_comb begin
    pair_hit  = (addr[ADDR_W-1:1] == BASE_TAG) && !iorq_n;
    hit_latch = pair_hit && !addr[0];
    hit_data  = pair_hit &&  addr[0];
  end

  always_comb begin
    if (!$isunknown({hit_latch, hit_data})) begin
      // R7
      one_port_chk: assert ($onehot0({hit_latch, hit_data}))
        else $error("both ports selected at once");
    end
    if (!$isunknown(iorq_n) && iorq_n) begin
      // R5
      no_req_no_hit_chk: assert (!hit_latch && !hit_data)
        else $error("port hit without I/O request");
    end
  end

endmodule

// File: rtl/snd_op_encode.sv
module snd_op_encode
  import snd_bus_pkg::*;
(
  input  logic    hit_latch,
  input  logic    hit_data,
  input  logic    rd_n,
  input  logic    wr_n,
  output snd_op_t op
);

  always_comb begin
    if (hit_latch) begin
      op = SND_LATCH;
    end else if (hit_data) begin
      op = snd_op_t'({!wr_n, !rd_n});
    end else begin
      op = SND_IDLE;
    end
  end

  always_comb begin
    if (!$isunknown({hit_latch, hit_data, op})) begin
      // R1
      latch_ignores_strobes_chk: assert (!hit_latch || op == SND_LATCH)
        else $error("latch port did not give latch op");
      // R6
      idle_on_miss_chk: assert (hit_latch || hit_data || op == SND_IDLE)
        else $error("op active with no port hit");
    end
  end

endmodule

// File: rtl/snd_bus_decoder.sv
module snd_bus_decoder
  import snd_bus_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_PORT = ADDR_W'(8)
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              bc1,
  output logic              bdir,
  output logic              bc2,
  output logic              csel_hi,
  output logic              csel_lo_n
);

  localparam logic [ADDR_W-1:0] RESERVED_TOP = ADDR_W'(8);

  // Elaboration-time guard on the port base
  if (BASE_PORT[0] || (BASE_PORT < RESERVED_TOP)) begin : g_bad_base
    $error("BASE_PORT must be even and not below 8");
  end

  logic    hit_latch;
  logic    hit_data;
  snd_op_t op;

  snd_port_match #(
    .ADDR_W    (ADDR_W),
    .BASE_PORT (BASE_PORT)
  ) u_match (
    .addr      (io_addr),
    .iorq_n    (iorq_n),
    .hit_latch (hit_latch),
    .hit_data  (hit_data)
  );

  snd_op_encode u_enc (
    .hit_latch (hit_latch),
    .hit_data  (hit_data),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .op        (op)
  );

  logic [1:0] op_bits;
  always_comb begin
    op_bits   = op;
    bc1       = op_bits[0];
    bdir      = op_bits[1];
    bc2       = BC2_LEVEL;
    csel_hi   = CSEL_HI_LEVEL;
    csel_lo_n = CSEL_LO_LEVEL;
  end

  localparam logic [ADDR_W-1:0] DATA_PORT = BASE_PORT + ADDR_W'(1);

  always_comb begin
    if (!$isunknown({io_addr, iorq_n, rd_n, wr_n, bc1, bdir})) begin
      // R5
      quiet_without_req_chk: assert (!iorq_n || (!bc1 && !bdir))
        else $error("control line active with no I/O request");
      // R1
      latch_port_chk: assert (iorq_n || io_addr != BASE_PORT || (bc1 && bdir))
        else $error("latch port did not raise both lines");
      // R9
      data_route_chk: assert (iorq_n || io_addr != DATA_PORT ||
                              (bc1 == !rd_n && bdir == !wr_n))
        else $error("data port strobe routing wrong");
      // R6
      miss_quiet_chk: assert (io_addr[ADDR_W-1:1] == BASE_PORT[ADDR_W-1:1] ||
                              (!bc1 && !bdir))
        else $error("control line active on foreign address");
    end
  end

endmodule

// File: tb/sim_snd_bus_decoder.sv
module sim_snd_bus_decoder;

  localparam logic [7:0] BASE = 8'h08;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] io_addr = 8'h00;
  logic iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic bc1, bdir, bc2, csel_hi, csel_lo_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  snd_bus_decoder #(.ADDR_W(8), .BASE_PORT(BASE)) u0 (
    .io_addr(io_addr), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .bc1(bc1), .bdir(bdir), .bc2(bc2), .csel_hi(csel_hi), .csel_lo_n(csel_lo_n)
  );

  // Expected {bdir, bc1} from the requirements
  function automatic logic [1:0] want(logic [7:0] a, logic rq, logic r, logic w);
    if (rq) return 2'b00;                 // R5
    if (a[7:1] != BASE[7:1]) return 2'b00; // R6
    if (!a[0]) return 2'b11;               // R1, R7
    return {!w, !r};                       // R2, R3, R4, R9
  endfunction

  task automatic apply(logic [7:0] a, logic rq, logic r, logic w);
    @(negedge clk);
    io_addr = a; iorq_n = rq; rd_n = r; wr_n = w;
    #1;
  endtask

  task automatic check_ctl(string req, logic [7:0] a, logic rq, logic r, logic w);
    logic [1:0] exp_v;
    apply(a, rq, r, w);
    exp_v = want(a, rq, r, w);
    checks++;
    if ({bdir, bc1} !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%02h iorq_n=%b rd_n=%b wr_n=%b: {bdir,bc1}=%b expected %b",
               req, a, rq, r, w, {bdir, bc1}, exp_v);
    end
  endtask

  task automatic check_fixed(string req);
    checks++;
    if ({bc2, csel_hi, csel_lo_n} !== 3'b110) begin
      errors++;
      $display("FAIL %s fixed pins {bc2,csel_hi,csel_lo_n}=%b expected 110",
               req, {bc2, csel_hi, csel_lo_n});
    end
  endtask

  task automatic t_idle_start;
    check_ctl("R5", BASE, 1'b1, 1'b1, 1'b1);
    check_fixed("R8");
  endtask

  task automatic t_latch;
    for (int s = 0; s < 4; s++) check_ctl("R1", BASE, 1'b0, s[0], s[1]);
    check_fixed("R8");
  endtask

  task automatic t_read;  check_ctl("R2", BASE + 8'd1, 1'b0, 1'b0, 1'b1); endtask
  task automatic t_write; check_ctl("R3", BASE + 8'd1, 1'b0, 1'b1, 1'b0); endtask
  task automatic t_no_strobe; check_ctl("R4", BASE + 8'd1, 1'b0, 1'b1, 1'b1); endtask
  task automatic t_both_strobes; check_ctl("R9", BASE + 8'd1, 1'b0, 1'b0, 1'b0); endtask

  task automatic t_select_bit;
    check_ctl("R7", BASE, 1'b0, 1'b1, 1'b1);
    check_ctl("R7", BASE + 8'd1, 1'b0, 1'b1, 1'b1);
    check_ctl("R7", BASE, 1'b0, 1'b0, 1'b1);
    check_ctl("R7", BASE + 8'd1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_miss_sweep;
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 4; s++)
        if (a[7:1] != int'(BASE[7:1])) check_ctl("R6", a[7:0], 1'b0, s[0], s[1]);
  endtask

  task automatic t_no_request_sweep;
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 4; s++) check_ctl("R5", a[7:0], 1'b1, s[0], s[1]);
    check_fixed("R8");
  endtask

  initial begin
    t_idle_start();
    t_latch();
    t_read();
    t_write();
    t_no_strobe();
    t_both_strobes();
    t_select_bit();
    t_miss_sweep();
    t_no_request_sweep();
    check_ctl("R5", BASE + 8'd1, 1'b1, 1'b0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule